// File: doc/BRIEF.md
# Transmit Checksum Inserter

This block sits in a transmit path in front of the MAC. For each frame it first takes a short control header on a 32-bit side stream, then takes the frame itself on a byte-wide data stream. It stores the whole frame in an internal buffer. While the bytes arrive, it keeps a running one's-complement sum that starts at a byte offset chosen by the header. After the last byte, the sum is completed: the header's seed is added, the result is folded and then complemented.

The frame is then sent out on a byte-wide output stream. The two checksum bytes take the place of the original bytes at the header's insertion offset. Because the whole frame is held, the insertion offset can lie anywhere in the frame, including before or inside the summed region.

At the end of the frame the block applies three checks, taken from its configuration pins and from the frame length. A frame that fails any of them is discarded without being sent. A one-cycle pulse marks the end of each frame that is sent.

Top module: `tx_csum_inserter`

## Requirements
- R1: The control header ends on the beat with `ctl_tlast` set.
  - A header of exactly 5 beats is well formed.
  - Any other length raises `hdr_err` for one cycle, in the cycle after the last header beat.
  - The frame that follows a malformed header is forwarded unmodified.
  - Beats after the fifth have no effect.
- R2: When bit 0 of header beat 0 is clear, the frame is forwarded byte for byte, with no checksum written.
- R3: The sum begins at the byte offset held in bits 31:16 of header beat 1 and runs to the end of the frame.
  - Bytes are taken in pairs, the first byte of each pair being the upper byte of a 16-bit word.
  - A single trailing byte is taken with a zero lower byte.
  - A start offset at or past the end of the frame sums no bytes.
- R4: The 16-bit seed in bits 15:0 of header beat 2 is added to the sum. The total is folded to 16 bits with end-around carry and then complemented.
- R5: The checksum's upper byte replaces the frame byte at the offset in bits 15:0 of header beat 1. Its lower byte replaces the byte after it. Any of these two positions at or past the end of the frame is simply not written.
- R6: The output frame has the same length as the input frame. It is identical to the input except for the inserted bytes, and this holds even when the insertion offset is before the start offset.
- R7: A frame that ends while `tx_en` is low is discarded.
- R8: The size rule applies while `jumbo_en` and `vlan_en` are both low.
  - Frames of 1519 to 1522 bytes are discarded.
  - Frames of 1518 or 1523 bytes pass.
  - With either pin high, a frame of 1519 to 1522 bytes passes.
- R9: A frame longer than `DEPTH` bytes is discarded. A frame of exactly `DEPTH` bytes is sent.
- R10: `tx_done` is high for exactly one cycle, the cycle after the last output beat is accepted.
- R11: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tlast` hold their values.
- R12: After reset the block is ready for a header, and not ready for data.
  - `ctl_tready` is 1.
  - `s_tready`, `m_tvalid`, `tx_done` and `hdr_err` are 0.
- R13: The data input is never ready while a header is being taken or while a frame is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable, sampled at end of frame |
| jumbo_en | input | 1 | Allow long frames |
| vlan_en | input | 1 | Allow tagged-frame sizes |
| ctl_tdata | input | 32 | Control header word |
| ctl_tvalid | input | 1 | Control header valid |
| ctl_tlast | input | 1 | Last header word |
| ctl_tready | output | 1 | Header ready |
| s_tdata | input | 8 | Frame byte in |
| s_tvalid | input | 1 | Frame byte valid |
| s_tlast | input | 1 | Last frame byte |
| s_tready | output | 1 | Frame input ready |
| m_tdata | output | 8 | Frame byte out |
| m_tvalid | output | 1 | Output valid |
| m_tlast | output | 1 | Last output byte |
| m_tready | input | 1 | Output ready |
| tx_done | output | 1 | Frame sent pulse |
| hdr_err | output | 1 | Malformed header pulse |

## Verification
Some internal faults appear within the same frame. A wrong running sum, a byte-pairing error or a wrong seed shows up in the two inserted bytes when that frame goes out. A wrong read pointer corrupts bytes away from the insertion point in that same frame.

Other faults appear only on the next frame. A stuck header counter or offload flag shows up as `hdr_err` misfiring or as a patch on the frame after a bad header. A wrong size or length decision leaves a frame missing or extra, which shows up as a mismatch on the very next output frame.

A reference model in the bench predicts every output byte and both pulses, and compares them on each clock.

// File: rtl/tx_csum_inserter.sv
module tx_csum_inserter #(
  parameter int DEPTH = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_en,
  input  logic        jumbo_en,
  input  logic        vlan_en,
  input  logic [31:0] ctl_tdata,
  input  logic        ctl_tvalid,
  input  logic        ctl_tlast,
  output logic        ctl_tready,
  input  logic [7:0]  s_tdata,
  input  logic        s_tvalid,
  input  logic        s_tlast,
  output logic        s_tready,
  output logic [7:0]  m_tdata,
  output logic        m_tvalid,
  output logic        m_tlast,
  input  logic        m_tready,
  output logic        tx_done,
  output logic        hdr_err
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [15:0] DEPTH_L = 16'(DEPTH);

  typedef enum logic [1:0] {ST_HDR, ST_RX, ST_FIN, ST_TX} st_t;

  st_t         st;
  logic [2:0]  hcnt;
  logic        hok, want;
  logic [15:0] start, woff, seed;
  logic [15:0] len, rd;
  logic [31:0] acc;
  logic [15:0] csum;
  logic [7:0]  mem [DEPTH];

  assign ctl_tready = (st == ST_HDR);
  assign s_tready   = (st == ST_RX);
  assign m_tvalid   = (st == ST_TX);

  wire ctl_hs = ctl_tvalid && ctl_tready;
  wire rx_hs  = s_tvalid && s_tready;
  wire tx_hs  = m_tvalid && m_tready;

  wire        rel_odd = len[0] ^ start[0];
  wire [15:0] word_in = rel_odd ? {8'h00, s_tdata} : {s_tdata, 8'h00};

  wire [31:0] tot = acc + {16'h0, seed};
  wire [16:0] f1  = {1'b0, tot[15:0]} + {1'b0, tot[31:16]};
  wire [15:0] f2  = f1[15:0] + {15'h0, f1[16]};

  wire size_bad = !jumbo_en && !vlan_en && len >= 16'd1519 && len <= 16'd1522;
  wire drop     = !tx_en || (len > DEPTH_L) || size_bad;

  wire        ofl   = hok && want;
  wire [16:0] wo_nx = {1'b0, woff} + 17'd1;
  wire        hit_hi = ofl && (rd == woff);
  wire        hit_lo = ofl && ({1'b0, rd} == wo_nx);

  assign m_tdata = hit_hi ? csum[15:8] : hit_lo ? csum[7:0] : mem[rd[AW-1:0]];
  assign m_tlast = (rd == len - 16'd1);

  always_ff @(posedge clk)
    if (rx_hs && len < DEPTH_L) mem[len[AW-1:0]] <= s_tdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_HDR;
      hcnt    <= '0;
      hok     <= 1'b0;
      want    <= 1'b0;
      start   <= '0;
      woff    <= '0;
      seed    <= '0;
      len     <= '0;
      rd      <= '0;
      acc     <= '0;
      csum    <= '0;
      tx_done <= 1'b0;
      hdr_err <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      hdr_err <= 1'b0;
      case (st)
        ST_HDR: if (ctl_hs) begin
          if (hcnt == 3'd0) want <= ctl_tdata[0];
          if (hcnt == 3'd1) begin
            start <= ctl_tdata[31:16];
            woff  <= ctl_tdata[15:0];
          end
          if (hcnt == 3'd2) seed <= ctl_tdata[15:0];
          if (hcnt != 3'd7) hcnt <= hcnt + 3'd1;
          if (ctl_tlast) begin
            hok     <= (hcnt == 3'd4);
            hdr_err <= (hcnt != 3'd4);
            hcnt    <= '0;
            len     <= '0;
            acc     <= '0;
            st      <= ST_RX;
          end
        end
        ST_RX: if (rx_hs) begin
          if (len >= start) acc <= acc + {16'h0, word_in};
          if (len != 16'hFFFF) len <= len + 16'd1;
          if (s_tlast) st <= ST_FIN;
        end
        ST_FIN: begin
          csum <= ~f2;
          rd   <= '0;
          st   <= drop ? ST_HDR : ST_TX;
        end
        ST_TX: if (tx_hs) begin
          rd <= rd + 16'd1;
          if (m_tlast) begin
            tx_done <= 1'b1;
            st      <= ST_HDR;
          end
        end
        default: st <= ST_HDR;
      endcase
    end
  end

endmodule

// File: rtl/tx_csum_inserter_chk.sv
module tx_csum_inserter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_tvalid,
  input logic       ctl_tready,
  input logic       ctl_tlast,
  input logic       s_tready,
  input logic       m_tvalid,
  input logic       m_tready,
  input logic       m_tlast,
  input logic [7:0] m_tdata,
  input logic       tx_done,
  input logic       hdr_err
);

  logic [2:0] nbeat;
  wire ctl_end = ctl_tvalid && ctl_tready && ctl_tlast;

  always_ff @(posedge clk)
    if (!rst_n) nbeat <= '0;
    else if (ctl_end) nbeat <= '0;
    else if (ctl_tvalid && ctl_tready && nbeat != 3'd7) nbeat <= nbeat + 3'd1;

  // R1
  hdr_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_end && nbeat == 3'd4 |=> !hdr_err);
  // R1
  hdr_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_end && nbeat != 3'd4 |=> hdr_err);
  // R1
  hdr_err_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |-> $past(ctl_end));
  // R10
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_tready && m_tlast |=> tx_done);
  // R10
  done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> $past(m_tvalid && m_tready && m_tlast));
  // R11
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));
  // R13
  no_rx_in_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_tready && s_tready));
  // R13
  no_rx_in_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_tready && m_tvalid));

endmodule

bind tx_csum_inserter tx_csum_inserter_chk u_chk (.*);

// File: tb/tx_csum_inserter_bench.sv
module tx_csum_inserter_bench;
  localparam int DEPTH = 1600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b1, jumbo_en = 1'b0, vlan_en = 1'b0;
  logic [31:0] ctl_tdata = '0;
  logic ctl_tvalid = 1'b0, ctl_tlast = 1'b0;
  logic ctl_tready;
  logic [7:0] s_tdata = '0;
  logic s_tvalid = 1'b0, s_tlast = 1'b0;
  logic s_tready;
  logic [7:0] m_tdata;
  logic m_tvalid, m_tlast;
  logic m_tready = 1'b0;
  logic tx_done, hdr_err;

  always #2.5 clk = ~clk;

  tx_csum_inserter #(.DEPTH(DEPTH)) u_tx_csum_inserter (.*);

  int nchk = 0, nfail = 0;
  logic [8:0] expq[$];
  string tagq[$];
  bit mon_on = 1'b0;

  task automatic chk(bit ok, string r, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
    end
  endtask

  // output backpressure
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      m_tready = (cyc % 4) != 1;
    end
  end

  // per-clock comparison against the reference queue
  bit pend_done = 0, pend_err = 0, prev_stall = 0, prev_last = 0;
  logic [7:0] prev_data = '0;
  int ctl_n = 0;
  always @(negedge clk) if (mon_on) begin
    chk(tx_done == pend_done, "R10 tx_done", tx_done, pend_done);
    chk(hdr_err == pend_err, "R1 hdr_err", hdr_err, pend_err);
    chk(!(s_tready && (ctl_tready || m_tvalid)), "R13 input ready", s_tready, 0);
    if (prev_stall)
      chk(m_tvalid && m_tdata == prev_data && m_tlast == prev_last, "R11 stall hold",
          {m_tvalid, m_tlast, m_tdata}, {1'b1, prev_last, prev_data});
    pend_done = 0;
    pend_err = 0;
    if (m_tvalid && m_tready) begin
      if (expq.size() == 0) chk(0, "R7/R8/R9 unexpected frame byte", m_tdata, 0);
      else begin
        logic [8:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk({m_tlast, m_tdata} == e, t, {m_tlast, m_tdata}, e);
      end
      pend_done = m_tlast;
    end
    if (ctl_tvalid && ctl_tready) begin
      ctl_n++;
      if (ctl_tlast) begin
        pend_err = (ctl_n != 5);
        ctl_n = 0;
      end
    end
    prev_stall = m_tvalid && !m_tready;
    prev_data = m_tdata;
    prev_last = m_tlast;
  end

  task automatic send_frame(int nw, bit en, int st, int wo, int sd, int n, int pat, string tag);
    logic [7:0] b[];
    bit dropit, ofl;
    longint acc;
    int cs;
    b = new[n];
    for (int i = 0; i < n; i++) b[i] = (pat < 0) ? 8'hFF : 8'((i * 7 + pat) % 256);
    dropit = !tx_en || n > DEPTH || (!jumbo_en && !vlan_en && n >= 1519 && n <= 1522);
    ofl = (nw == 5) && en;
    if (ofl) begin
      acc = 0;
      for (int i = st; i < n; i += 2)
        acc += (longint'(b[i]) << 8) + ((i + 1 < n) ? longint'(b[i + 1]) : 0);
      acc += sd;
      while (acc > 65535) acc = (acc & 65535) + (acc >> 16);
      cs = int'(~acc & 65535);
      if (wo < n) b[wo] = 8'(cs >> 8);
      if (wo + 1 < n) b[wo + 1] = 8'(cs & 255);
    end
    if (!dropit)
      for (int i = 0; i < n; i++) begin
        expq.push_back({i == n - 1, b[i]});
        tagq.push_back(tag);
      end
    for (int k = 0; k < nw; k++) begin
      ctl_tdata = (k == 0) ? {31'h0, en} : (k == 1) ? {st[15:0], wo[15:0]} :
                  (k == 2) ? {16'hC3C3, sd[15:0]} : (32'h5A5A0000 | k);
      ctl_tlast = (k == nw - 1);
      ctl_tvalid = 1'b1;
      do @(negedge clk); while (!ctl_tready);
      @(posedge clk); #1;
    end
    ctl_tvalid = 1'b0;
    ctl_tlast = 1'b0;
    for (int i = 0; i < n; i++) begin
      s_tdata = (pat < 0) ? 8'hFF : 8'((i * 7 + pat) % 256);
      s_tlast = (i == n - 1);
      s_tvalid = 1'b1;
      do @(negedge clk); while (!s_tready);
      @(posedge clk); #1;
    end
    s_tvalid = 1'b0;
    s_tlast = 1'b0;
    repeat (3) @(negedge clk);
    while (!ctl_tready || expq.size() != 0) @(negedge clk);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    chk(ctl_tready == 1, "R12 ctl_tready", ctl_tready, 1);
    chk(s_tready == 0, "R12 s_tready", s_tready, 0);
    chk(m_tvalid == 0, "R12 m_tvalid", m_tvalid, 0);
    chk(tx_done == 0 && hdr_err == 0, "R12 pulses", {tx_done, hdr_err}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    mon_on = 1'b1;
    send_frame(5, 0, 4, 6, 16'h1111, 20, 3, "R2 offload off");
    send_frame(5, 1, 14, 30, 16'h1234, 60, 5, "R3 R4 R5 even frame");
    send_frame(5, 1, 15, 40, 16'h0042, 61, 9, "R3 odd start odd length");
    send_frame(5, 1, 70, 10, 16'hBEEF, 64, 1, "R3 start past end");
    send_frame(5, 1, 10, 2, 16'h0000, 48, 11, "R6 insert before start");
    send_frame(5, 1, 0, 39, 16'h0001, 40, 13, "R5 partial insert at end");
    send_frame(5, 1, 0, 45, 16'h0001, 40, 13, "R5 insert past end");
    send_frame(5, 1, 0, 8, 16'hFFFF, 33, -1, "R4 end-around carry");
    send_frame(4, 1, 0, 2, 16'h0007, 24, 17, "R1 short header");
    send_frame(6, 1, 0, 2, 16'h0007, 24, 17, "R1 long header");
    send_frame(5, 1, 0, 2, 16'h0007, 24, 17, "R1 good header after bad");
    tx_en = 1'b0;
    send_frame(5, 1, 0, 2, 16'h0007, 30, 19, "R7 disabled");
    tx_en = 1'b1;
    send_frame(5, 1, 0, 2, 16'h0007, 30, 23, "R7 enabled again");
    send_frame(5, 1, 14, 20, 16'h0100, 1518, 2, "R8 1518 passes");
    send_frame(5, 1, 14, 20, 16'h0100, 1519, 2, "R8 1519 dropped");
    send_frame(5, 1, 14, 20, 16'h0100, 1522, 2, "R8 1522 dropped");
    send_frame(5, 1, 14, 20, 16'h0100, 1523, 2, "R8 1523 passes");
    vlan_en = 1'b1;
    send_frame(5, 1, 14, 20, 16'h0100, 1520, 4, "R8 vlan allows");
    vlan_en = 1'b0;
    jumbo_en = 1'b1;
    send_frame(5, 1, 14, 20, 16'h0100, 1521, 6, "R8 jumbo allows");
    send_frame(5, 1, 14, 20, 16'h0100, DEPTH + 1, 6, "R9 too long dropped");
    send_frame(5, 1, 14, DEPTH - 2, 16'h0100, DEPTH, 8, "R9 full depth");
    jumbo_en = 1'b0;
    send_frame(5, 1, 1, 3, 16'h2222, 12, 29, "R6 short frame after drops");
    repeat (10) @(negedge clk);
    chk(expq.size() == 0, "R7/R9 pending bytes", expq.size(), 0);
    mon_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule